// File: doc/BRIEF.md
# Multichannel Controller Action Request Processor

This block runs the configuration side of a 32-channel serial controller. The host writes a 32-bit action word to register offset 0. The block decodes the word and runs one or more reload procedures against a word-addressed configuration memory. The procedures copy timeslot assignment words and per-channel specification records into shadow registers. After each reload procedure the block can post an acknowledge entry to the interrupt queue writer.

A reload procedure is chosen by a flag bit in the action word. One flag reloads the timeslot map and a single named channel. One reloads only the named channel. One reloads the timeslot map and every channel. A fourth flag reads the interrupt queue base address and size code. When a channel is loaded, its current transmit descriptor pointer is written back to a per-channel slot in the configuration memory. While a request is in progress, `busy` stays high and further host action writes are dropped.

The shadow contents are read out combinationally through two index inputs: one selects a timeslot word and one selects a channel record.

Top module: `mcx_action_seq`

## Requirements
- R1: After reset, `busy`, `iqReq`, `cfgRdEn` and `cfgWrEn` are low, and every shadow output (timeslot words, channel fields, queue base and size code) reads zero.
- R2: An action is accepted only when all of the following hold: `hostWrEn` is high, `hostWrAddr` is 0, and the block is idle. A write to any other offset causes no configuration memory access, and `busy` stays low.
- R3: The action word fields used by the block are: flag bit 2 (queue setup), bit 15 (full init), bit 14 (channel-only init), bit 6 (full reset), bit 7 (acknowledge mask), and the channel number in bits 12:8. Bits 31:16, 13, 5:3 and 1:0 have no effect.
- R4: Queue setup reads configuration word 1 into `iqBase`, then reads configuration word 2 and places its low byte on `iqSizeCode`.
- R5: Full init reads timeslot words 3 through 34 in ascending order. It then loads the named channel from words 35+4·ch through 38+4·ch, in the order status, first receive pointer, first transmit pointer, buffer size. It then writes the first transmit pointer to word 195+ch.
- R6: Channel-only init loads and writes back only the named channel, with the same word order as R5, and reads no timeslot word.
- R7: Full reset reads all 32 timeslot words, then loads channels 0 through 31 in ascending order. Each channel's write-back follows its fourth read.
- R8: After a channel is loaded, `chRxCur` equals its first receive pointer and `chTxCur` equals its first transmit pointer. All six channel fields appear for the index on `chRdIdx`, and timeslot word i appears on `tsRdWord` when `tsRdIdx` is i.
- R9: Each full init, channel-only init or full reset posts exactly one acknowledge word 0x80008000 on `iqData`, unless bit 7 is set. `iqReq` and `iqData` hold steady until `iqGrant` is seen high.
- R10: When several flags are set in one word, they run in the order queue setup, full init, channel-only init, full reset.
- R11: `busy` rises in the cycle after an accepted write and stays high until the last read, write-back and acknowledge are done. Action writes that arrive while busy are ignored.
- R12: Configuration reads have one cycle of latency: `cfgRdData` is taken in the cycle after `cfgRdEn`. Reads and write-backs never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostWrAddr | input | HOST_AW | Host register byte offset |
| hostWrData | input | 32 | Host write data (action word at offset 0) |
| cfgAddr | output | CFG_AW | Configuration memory word address |
| cfgRdEn | output | 1 | Configuration memory read strobe |
| cfgRdData | input | 32 | Read data, valid one cycle after cfgRdEn |
| cfgWrEn | output | 1 | Configuration memory write strobe |
| cfgWrData | output | 32 | Configuration memory write data |
| iqReq | output | 1 | Acknowledge post request |
| iqData | output | 32 | Acknowledge word to post |
| iqGrant | input | 1 | Queue writer accepts the posted word |
| busy | output | 1 | Action in progress |
| tsRdIdx | input | 5 | Timeslot shadow select |
| tsRdWord | output | 32 | Selected timeslot shadow word |
| chRdIdx | input | 5 | Channel shadow select |
| chStatus | output | 32 | Selected channel status word |
| chRxFirst | output | 32 | Selected channel first receive pointer |
| chTxFirst | output | 32 | Selected channel first transmit pointer |
| chBufSize | output | 32 | Selected channel buffer size word |
| chRxCur | output | 32 | Selected channel current receive pointer |
| chTxCur | output | 32 | Selected channel current transmit pointer |
| iqBase | output | 32 | Interrupt queue base address |
| iqSizeCode | output | 8 | Interrupt queue size code |

## Verification
The assertions assume two things about the surroundings. First, `iqGrant` is raised only while `iqReq` is high, and for one cycle at a time. Second, the memory returns read data one cycle after the strobe. The bench's grant model is registered and only raises grant in response to a pending request, then drops it right away. The bench's memory model registers its read data on the edge that samples `cfgRdEn`. Host writes are driven on the falling edge. They include writes during busy and writes to a nonzero offset, so the assertion tying a rising `busy` to an offset-0 write is exercised against both dropped and accepted writes.

// File: rtl/mcx_action_pkg.sv
package mcx_action_pkg;

  localparam int IDX_W = 5;

  typedef enum logic [2:0] {
    AK_IQBASE,
    AK_IQSIZE,
    AK_TSLOT,
    AK_CHSPEC,
    AK_TXBACK
  } addrKind_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic             rdIssue;
    logic             capture;
    logic             wrBack;
    addrKind_e        kind;
    logic [IDX_W-1:0] tsIdx;
    logic [IDX_W-1:0] chIdx;
    logic [1:0]       wordIdx;
  } seqStrobe_t;

  localparam logic [31:0] ACK_WORD = 32'h8000_8000;

endpackage

// File: rtl/mcx_action_ctrl.sv
module mcx_action_ctrl
  import mcx_action_pkg::*;
#(
  parameter int NUM_TS  = 32,
  parameter int NUM_CH  = 32,
  parameter int HOST_AW = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWrEn,
  input  logic [HOST_AW-1:0] hostWrAddr,
  input  logic [31:0]        hostWrData,
  input  logic               iqGrant,
  output logic               iqReq,
  output logic [31:0]        iqData,
  output logic               busy,
  output seqStrobe_t         strobe
);

  localparam logic [IDX_W-1:0] TS_LAST = IDX_W'(NUM_TS - 1);
  localparam logic [IDX_W-1:0] CH_LAST = IDX_W'(NUM_CH - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_DISPATCH,
    S_IQB_RD, S_IQB_CAP, S_IQS_RD, S_IQS_CAP,
    S_TS_RD, S_TS_CAP,
    S_CH_RD, S_CH_CAP, S_CH_WB,
    S_ACK
  } seqState_e;

  seqState_e        state;
  logic             pendIa, pendIn, pendIco, pendRes;
  logic             ackMask;
  logic             allCh;
  logic [IDX_W-1:0] chanSel;
  logic [IDX_W-1:0] tsIdx;
  logic [IDX_W-1:0] chIdx;
  logic [1:0]       wordIdx;

  wire actionHit = hostWrEn && (hostWrAddr == '0) && (state == S_IDLE);

  // Fields outside the decoded set are deliberately dropped
  logic unusedFields;
  assign unusedFields = ^{hostWrData[31:16], hostWrData[13], hostWrData[5:3], hostWrData[1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      pendIa  <= 1'b0;
      pendIn  <= 1'b0;
      pendIco <= 1'b0;
      pendRes <= 1'b0;
      ackMask <= 1'b0;
      allCh   <= 1'b0;
      chanSel <= '0;
      tsIdx   <= '0;
      chIdx   <= '0;
      wordIdx <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (actionHit) begin
            pendIa  <= hostWrData[2];
            pendIn  <= hostWrData[15];
            pendIco <= hostWrData[14];
            pendRes <= hostWrData[6];
            ackMask <= hostWrData[7];
            chanSel <= hostWrData[8 +: IDX_W];
            state   <= S_DISPATCH;
          end
        end
        S_DISPATCH: begin
          if (pendIa) begin
            pendIa <= 1'b0;
            state  <= S_IQB_RD;
          end else if (pendIn) begin
            pendIn  <= 1'b0;
            allCh   <= 1'b0;
            chIdx   <= chanSel;
            tsIdx   <= '0;
            wordIdx <= '0;
            state   <= S_TS_RD;
          end else if (pendIco) begin
            pendIco <= 1'b0;
            allCh   <= 1'b0;
            chIdx   <= chanSel;
            wordIdx <= '0;
            state   <= S_CH_RD;
          end else if (pendRes) begin
            pendRes <= 1'b0;
            allCh   <= 1'b1;
            chIdx   <= '0;
            tsIdx   <= '0;
            wordIdx <= '0;
            state   <= S_TS_RD;
          end else begin
            state <= S_IDLE;
          end
        end
        S_IQB_RD:  state <= S_IQB_CAP;
        S_IQB_CAP: state <= S_IQS_RD;
        S_IQS_RD:  state <= S_IQS_CAP;
        S_IQS_CAP: state <= S_DISPATCH;
        S_TS_RD:   state <= S_TS_CAP;
        S_TS_CAP: begin
          if (tsIdx == TS_LAST) begin
            wordIdx <= '0;
            state   <= S_CH_RD;
          end else begin
            tsIdx <= tsIdx + 1'b1;
            state <= S_TS_RD;
          end
        end
        S_CH_RD: state <= S_CH_CAP;
        S_CH_CAP: begin
          if (wordIdx == 2'd3) begin
            state <= S_CH_WB;
          end else begin
            wordIdx <= wordIdx + 1'b1;
            state   <= S_CH_RD;
          end
        end
        S_CH_WB: begin
          if (allCh && (chIdx != CH_LAST)) begin
            chIdx   <= chIdx + 1'b1;
            wordIdx <= '0;
            state   <= S_CH_RD;
          end else if (ackMask) begin
            state <= S_DISPATCH;
          end else begin
            state <= S_ACK;
          end
        end
        S_ACK: begin
          if (iqGrant) state <= S_DISPATCH;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.tsIdx   = tsIdx;
    strobe.chIdx   = chIdx;
    strobe.wordIdx = wordIdx;
    strobe.kind    = AK_TSLOT;
    case (state)
      S_IQB_RD:  begin strobe.rdIssue = 1'b1; strobe.kind = AK_IQBASE; end
      S_IQB_CAP: begin strobe.capture = 1'b1; strobe.kind = AK_IQBASE; end
      S_IQS_RD:  begin strobe.rdIssue = 1'b1; strobe.kind = AK_IQSIZE; end
      S_IQS_CAP: begin strobe.capture = 1'b1; strobe.kind = AK_IQSIZE; end
      S_TS_RD:   begin strobe.rdIssue = 1'b1; strobe.kind = AK_TSLOT;  end
      S_TS_CAP:  begin strobe.capture = 1'b1; strobe.kind = AK_TSLOT;  end
      S_CH_RD:   begin strobe.rdIssue = 1'b1; strobe.kind = AK_CHSPEC; end
      S_CH_CAP:  begin strobe.capture = 1'b1; strobe.kind = AK_CHSPEC; end
      S_CH_WB:   begin strobe.wrBack  = 1'b1; strobe.kind = AK_TXBACK; end
      default: ;
    endcase
  end

  assign busy   = (state != S_IDLE);
  assign iqReq  = (state == S_ACK);
  assign iqData = iqReq ? ACK_WORD : '0;

endmodule

// File: rtl/mcx_action_dp.sv
module mcx_action_dp
  import mcx_action_pkg::*;
#(
  parameter int NUM_TS        = 32,
  parameter int NUM_CH        = 32,
  parameter int CFG_AW        = 16,
  parameter int IQ_BASE_WORD  = 1,
  parameter int IQ_SIZE_WORD  = 2,
  parameter int TS_BASE_WORD  = 3,
  parameter int CH_BASE_WORD  = 35,
  parameter int TXBACK_WORD   = 195
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [31:0]       cfgRdData,
  output logic [CFG_AW-1:0] cfgAddr,
  output logic              cfgRdEn,
  output logic              cfgWrEn,
  output logic [31:0]       cfgWrData,
  input  logic [IDX_W-1:0]  tsRdIdx,
  output logic [31:0]       tsRdWord,
  input  logic [IDX_W-1:0]  chRdIdx,
  output logic [31:0]       chStatus,
  output logic [31:0]       chRxFirst,
  output logic [31:0]       chTxFirst,
  output logic [31:0]       chBufSize,
  output logic [31:0]       chRxCur,
  output logic [31:0]       chTxCur,
  output logic [31:0]       iqBase,
  output logic [7:0]        iqSizeCode
);

  localparam int WORDS_PER_CH = 4;
  localparam int CH_SHIFT     = $clog2(WORDS_PER_CH);

  logic [31:0] tsShadow  [NUM_TS];
  logic [31:0] stShadow  [NUM_CH];
  logic [31:0] rxFirstR  [NUM_CH];
  logic [31:0] txFirstR  [NUM_CH];
  logic [31:0] bufSizeR  [NUM_CH];
  logic [31:0] rxCurR    [NUM_CH];
  logic [31:0] txCurR    [NUM_CH];
  logic [31:0] iqBaseR;
  logic [7:0]  iqSizeR;

  // Word address generation per access kind
  always_comb begin
    case (strobe.kind)
      AK_IQBASE: cfgAddr = CFG_AW'(IQ_BASE_WORD);
      AK_IQSIZE: cfgAddr = CFG_AW'(IQ_SIZE_WORD);
      AK_TSLOT:  cfgAddr = CFG_AW'(TS_BASE_WORD) + CFG_AW'(strobe.tsIdx);
      AK_CHSPEC: cfgAddr = CFG_AW'(CH_BASE_WORD)
                         + (CFG_AW'(strobe.chIdx) << CH_SHIFT)
                         + CFG_AW'(strobe.wordIdx);
      AK_TXBACK: cfgAddr = CFG_AW'(TXBACK_WORD) + CFG_AW'(strobe.chIdx);
      default:   cfgAddr = '0;
    endcase
  end

  assign cfgRdEn   = strobe.rdIssue;
  assign cfgWrEn   = strobe.wrBack;
  assign cfgWrData = txCurR[strobe.chIdx];

  // Timeslot shadow bank
  generate
    for (genvar t = 0; t < NUM_TS; t++) begin : g_ts
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          tsShadow[t] <= '0;
        end else if (strobe.capture && strobe.kind == AK_TSLOT
                     && strobe.tsIdx == IDX_W'(t)) begin
          tsShadow[t] <= cfgRdData;
        end
      end
    end
  endgenerate

  // Channel record bank
  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      wire hitCh = strobe.capture && strobe.kind == AK_CHSPEC
                   && strobe.chIdx == IDX_W'(c);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stShadow[c] <= '0;
          rxFirstR[c] <= '0;
          txFirstR[c] <= '0;
          bufSizeR[c] <= '0;
          rxCurR[c]   <= '0;
          txCurR[c]   <= '0;
        end else if (hitCh) begin
          case (strobe.wordIdx)
            2'd0: stShadow[c] <= cfgRdData;
            2'd1: begin
              rxFirstR[c] <= cfgRdData;
              rxCurR[c]   <= cfgRdData;
            end
            2'd2: begin
              txFirstR[c] <= cfgRdData;
              txCurR[c]   <= cfgRdData;
            end
            default: bufSizeR[c] <= cfgRdData;
          endcase
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iqBaseR <= '0;
      iqSizeR <= '0;
    end else if (strobe.capture) begin
      if (strobe.kind == AK_IQBASE) iqBaseR <= cfgRdData;
      if (strobe.kind == AK_IQSIZE) iqSizeR <= cfgRdData[7:0];
    end
  end

  assign tsRdWord   = tsShadow[tsRdIdx];
  assign chStatus   = stShadow[chRdIdx];
  assign chRxFirst  = rxFirstR[chRdIdx];
  assign chTxFirst  = txFirstR[chRdIdx];
  assign chBufSize  = bufSizeR[chRdIdx];
  assign chRxCur    = rxCurR[chRdIdx];
  assign chTxCur    = txCurR[chRdIdx];
  assign iqBase     = iqBaseR;
  assign iqSizeCode = iqSizeR;

endmodule

// File: rtl/mcx_action_seq.sv
module mcx_action_seq
  import mcx_action_pkg::*;
#(
  parameter int NUM_TS       = 32,
  parameter int NUM_CH       = 32,
  parameter int HOST_AW      = 8,
  parameter int CFG_AW       = 16,
  parameter int IQ_BASE_WORD = 1,
  parameter int IQ_SIZE_WORD = 2,
  parameter int TS_BASE_WORD = 3,
  parameter int CH_BASE_WORD = 35,
  parameter int TXBACK_WORD  = 195
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWrEn,
  input  logic [HOST_AW-1:0] hostWrAddr,
  input  logic [31:0]        hostWrData,
  output logic [CFG_AW-1:0]  cfgAddr,
  output logic               cfgRdEn,
  input  logic [31:0]        cfgRdData,
  output logic               cfgWrEn,
  output logic [31:0]        cfgWrData,
  output logic               iqReq,
  output logic [31:0]        iqData,
  input  logic               iqGrant,
  output logic               busy,
  input  logic [IDX_W-1:0]   tsRdIdx,
  output logic [31:0]        tsRdWord,
  input  logic [IDX_W-1:0]   chRdIdx,
  output logic [31:0]        chStatus,
  output logic [31:0]        chRxFirst,
  output logic [31:0]        chTxFirst,
  output logic [31:0]        chBufSize,
  output logic [31:0]        chRxCur,
  output logic [31:0]        chTxCur,
  output logic [31:0]        iqBase,
  output logic [7:0]         iqSizeCode
);

  seqStrobe_t strobe;

  mcx_action_ctrl #(
    .NUM_TS (NUM_TS),
    .NUM_CH (NUM_CH),
    .HOST_AW(HOST_AW)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostWrEn  (hostWrEn),
    .hostWrAddr(hostWrAddr),
    .hostWrData(hostWrData),
    .iqGrant   (iqGrant),
    .iqReq     (iqReq),
    .iqData    (iqData),
    .busy      (busy),
    .strobe    (strobe)
  );

  mcx_action_dp #(
    .NUM_TS      (NUM_TS),
    .NUM_CH      (NUM_CH),
    .CFG_AW      (CFG_AW),
    .IQ_BASE_WORD(IQ_BASE_WORD),
    .IQ_SIZE_WORD(IQ_SIZE_WORD),
    .TS_BASE_WORD(TS_BASE_WORD),
    .CH_BASE_WORD(CH_BASE_WORD),
    .TXBACK_WORD (TXBACK_WORD)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cfgRdData (cfgRdData),
    .cfgAddr   (cfgAddr),
    .cfgRdEn   (cfgRdEn),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .tsRdIdx   (tsRdIdx),
    .tsRdWord  (tsRdWord),
    .chRdIdx   (chRdIdx),
    .chStatus  (chStatus),
    .chRxFirst (chRxFirst),
    .chTxFirst (chTxFirst),
    .chBufSize (chBufSize),
    .chRxCur   (chRxCur),
    .chTxCur   (chTxCur),
    .iqBase    (iqBase),
    .iqSizeCode(iqSizeCode)
  );

endmodule

// File: rtl/mcx_action_chk.sv
module mcx_action_chk #(
  parameter int NUM_CH       = 32,
  parameter int HOST_AW      = 8,
  parameter int CFG_AW       = 16,
  parameter int CH_BASE_WORD = 35,
  parameter int TXBACK_WORD  = 195
) (
  input logic               clk,
  input logic               rstN,
  input logic               hostWrEn,
  input logic [HOST_AW-1:0] hostWrAddr,
  input logic [CFG_AW-1:0]  cfgAddr,
  input logic               cfgRdEn,
  input logic               cfgWrEn,
  input logic               iqReq,
  input logic [31:0]        iqData,
  input logic               iqGrant,
  input logic               busy
);

  localparam int RD_LIMIT = CH_BASE_WORD + 4 * NUM_CH;
  localparam int WB_LIMIT = TXBACK_WORD + NUM_CH;

  // R9: a pending acknowledge is held unchanged until granted
  p_ack_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (iqReq && !iqGrant) |=> (iqReq && $stable(iqData)));

  // R11: no memory or queue traffic while idle
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!cfgRdEn && !cfgWrEn && !iqReq));

  // R2: busy only starts after a host write to offset 0
  p_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(hostWrEn && (hostWrAddr == '0)));

  // R12: read and write-back never share a cycle
  p_rw_excl_r12: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |-> !cfgRdEn);

  // R5: write-backs land inside the transmit pointer slots
  p_wb_window_r5: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |-> (int'(cfgAddr) >= TXBACK_WORD && int'(cfgAddr) < WB_LIMIT));

  // R3: reads stay inside the queue, timeslot and channel areas
  p_rd_window_r3: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdEn |-> (int'(cfgAddr) >= 1 && int'(cfgAddr) < RD_LIMIT));

endmodule

bind mcx_action_seq mcx_action_chk #(
  .NUM_CH      (NUM_CH),
  .HOST_AW     (HOST_AW),
  .CFG_AW      (CFG_AW),
  .CH_BASE_WORD(CH_BASE_WORD),
  .TXBACK_WORD (TXBACK_WORD)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hostWrEn  (hostWrEn),
  .hostWrAddr(hostWrAddr),
  .cfgAddr   (cfgAddr),
  .cfgRdEn   (cfgRdEn),
  .cfgWrEn   (cfgWrEn),
  .iqReq     (iqReq),
  .iqData    (iqData),
  .iqGrant   (iqGrant),
  .busy      (busy)
);

// File: tb/test_mcx_action_seq.sv
module test_mcx_action_seq;

  localparam int NTS = 32;
  localparam int NCH = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [7:0]  hostWrAddr = '0;
  logic [31:0] hostWrData = '0;
  logic [15:0] cfgAddr;
  logic        cfgRdEn;
  logic [31:0] cfgRdData = '0;
  logic        cfgWrEn;
  logic [31:0] cfgWrData;
  logic        iqReq;
  logic [31:0] iqData;
  logic        iqGrant = 1'b0;
  logic        busy;
  logic [4:0]  tsRdIdx = '0;
  logic [31:0] tsRdWord;
  logic [4:0]  chRdIdx = '0;
  logic [31:0] chStatus, chRxFirst, chTxFirst, chBufSize, chRxCur, chTxCur;
  logic [31:0] iqBase;
  logic [7:0]  iqSizeCode;

  always #10 clk = ~clk;

  mcx_action_seq i_mcx_action_seq (
    .clk(clk), .rstN(rstN),
    .hostWrEn(hostWrEn), .hostWrAddr(hostWrAddr), .hostWrData(hostWrData),
    .cfgAddr(cfgAddr), .cfgRdEn(cfgRdEn), .cfgRdData(cfgRdData),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .iqReq(iqReq), .iqData(iqData), .iqGrant(iqGrant), .busy(busy),
    .tsRdIdx(tsRdIdx), .tsRdWord(tsRdWord), .chRdIdx(chRdIdx),
    .chStatus(chStatus), .chRxFirst(chRxFirst), .chTxFirst(chTxFirst),
    .chBufSize(chBufSize), .chRxCur(chRxCur), .chTxCur(chTxCur),
    .iqBase(iqBase), .iqSizeCode(iqSizeCode)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [31:0] mem [256];
  int          expRd[$];
  int          expWrA[$];
  logic [31:0] expWrD[$];
  int          expAcks = 0;
  int          seenAcks = 0;
  logic [31:0] expTs [NTS];
  logic [31:0] expCh [NCH][4];
  logic [31:0] expIqBase = '0;
  logic [7:0]  expIqSize = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory and queue models, plus access order checks (R5 R6 R7 R10 R12)
  always @(posedge clk) begin
    if (cfgRdEn) begin
      if (expRd.size() == 0) check(0, "R2/R11 unexpected read", 32'(cfgAddr), 32'hffff_ffff);
      else check(int'(cfgAddr) == expRd.pop_front(), "R10 read order", 32'(cfgAddr), 32'h0);
      cfgRdData <= mem[cfgAddr[7:0]];
    end
    if (cfgWrEn) begin
      if (expWrA.size() == 0) check(0, "R5 unexpected write-back", 32'(cfgAddr), 32'hffff_ffff);
      else begin
        int a;
        logic [31:0] d;
        a = expWrA.pop_front();
        d = expWrD.pop_front();
        check(int'(cfgAddr) == a, "R5 write-back address", 32'(cfgAddr), 32'(a));
        check(cfgWrData == d, "R5 write-back data", cfgWrData, d);
      end
      mem[cfgAddr[7:0]] = cfgWrData;
    end
    if (iqReq && iqGrant) begin
      seenAcks++;
      check(iqData == 32'h8000_8000, "R9 ack word", iqData, 32'h8000_8000);
    end
    iqGrant <= iqReq && !iqGrant && ($urandom % 3 == 0);
  end

  function automatic void loadCh(input int c);
    for (int k = 0; k < 4; k++) begin
      expRd.push_back(35 + 4 * c + k);
      expCh[c][k] = mem[35 + 4 * c + k];
    end
    expWrA.push_back(195 + c);
    expWrD.push_back(mem[35 + 4 * c + 2]);
  endfunction

  function automatic void loadTs();
    for (int t = 0; t < NTS; t++) begin
      expRd.push_back(3 + t);
      expTs[t] = mem[3 + t];
    end
  endfunction

  // Expected effect of one action word (R3 R4 R5 R6 R7 R9 R10)
  function automatic void model(input logic [31:0] w);
    int c;
    c = int'(w[12:8]);
    if (w[2]) begin
      expRd.push_back(1);
      expRd.push_back(2);
      expIqBase = mem[1];
      expIqSize = mem[2][7:0];
    end
    if (w[15]) begin
      loadTs();
      loadCh(c);
      if (!w[7]) expAcks++;
    end
    if (w[14]) begin
      loadCh(c);
      if (!w[7]) expAcks++;
    end
    if (w[6]) begin
      loadTs();
      for (int i = 0; i < NCH; i++) loadCh(i);
      if (!w[7]) expAcks++;
    end
  endfunction

  task automatic hostWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    hostWrEn = 1'b1;
    hostWrAddr = a;
    hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
    hostWrAddr = '0;
  endtask

  task automatic runAction(input logic [31:0] w);
    model(w);
    hostWrite(8'h00, w);
    check(busy == 1'b1, "R11 busy after accept", 32'(busy), 32'd1);
    while (busy) @(negedge clk);
    check(expRd.size() == 0, "R10 all reads done", 32'(expRd.size()), 32'd0);
    check(expWrA.size() == 0, "R5 all write-backs done", 32'(expWrA.size()), 32'd0);
    check(seenAcks == expAcks, "R9 ack count", 32'(seenAcks), 32'(expAcks));
  endtask

  task automatic checkShadows();
    for (int t = 0; t < NTS; t++) begin
      tsRdIdx = 5'(t);
      #1;
      check(tsRdWord == expTs[t], "R8 timeslot shadow", tsRdWord, expTs[t]);
    end
    for (int c = 0; c < NCH; c++) begin
      chRdIdx = 5'(c);
      #1;
      check(chStatus  == expCh[c][0], "R8 status", chStatus, expCh[c][0]);
      check(chRxFirst == expCh[c][1], "R8 rx first", chRxFirst, expCh[c][1]);
      check(chTxFirst == expCh[c][2], "R8 tx first", chTxFirst, expCh[c][2]);
      check(chBufSize == expCh[c][3], "R8 buf size", chBufSize, expCh[c][3]);
      check(chRxCur   == expCh[c][1], "R8 rx current", chRxCur, expCh[c][1]);
      check(chTxCur   == expCh[c][2], "R8 tx current", chTxCur, expCh[c][2]);
    end
    check(iqBase == expIqBase, "R4 queue base", iqBase, expIqBase);
    check(iqSizeCode == expIqSize, "R4 queue size", 32'(iqSizeCode), 32'(expIqSize));
  endtask

  task automatic fillMem();
    for (int i = 0; i < 195; i++) mem[i] = $urandom;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int t = 0; t < NTS; t++) expTs[t] = '0;
    for (int c = 0; c < NCH; c++) for (int k = 0; k < 4; k++) expCh[c][k] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 0, "R1 busy", 32'(busy), 0);
    check(iqReq == 0, "R1 iqReq", 32'(iqReq), 0);
    check(cfgRdEn == 0 && cfgWrEn == 0, "R1 memory strobes", 32'({cfgRdEn, cfgWrEn}), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkShadows();
    fillMem();

    // R2: write to a nonzero offset is ignored
    hostWrite(8'h04, 32'h0000_C044);
    repeat (4) begin
      check(busy == 0, "R2 offset ignored", 32'(busy), 0);
      @(negedge clk);
    end

    // R4 / R10: queue setup ahead of full init
    runAction(32'h0000_8304);
    checkShadows();

    // R6: channel-only init with all unused fields set (R3)
    fillMem();
    runAction(32'hFFFF_6E3B & ~32'h0000_80C4 | 32'h0000_4000);
    checkShadows();

    // R7 with ack masked (R9), then R11: writes while busy are dropped
    fillMem();
    model(32'h0000_00C0);
    hostWrite(8'h00, 32'h0000_00C0);
    repeat (10) @(negedge clk);
    hostWrite(8'h00, 32'h0000_C044);
    while (busy) @(negedge clk);
    check(expRd.size() == 0, "R11 dropped write", 32'(expRd.size()), 0);
    check(seenAcks == expAcks, "R9 masked ack", 32'(seenAcks), 32'(expAcks));
    checkShadows();

    // R10: all flags, in one word
    fillMem();
    runAction(32'h0000_DF44);
    checkShadows();

    // Constrained random actions
    for (int it = 0; it < 8; it++) begin
      logic [31:0] w;
      fillMem();
      w = $urandom;
      if (it % 3 != 0) w[6] = 1'b0;
      runAction(w);
      checkShadows();
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule